// File: doc/BRIEF.md
# Cascadable Nibble Magnitude Comparator

This block compares two unsigned words and reports one of three relations on active-high outputs: A above B, A below B, or A matching B. It is built from identical 4-bit slices. Each slice decides on the most significant bit where its two nibbles differ. When its nibbles match, the slice hands the relation from the next lower slice straight through to its own outputs.

The top level chains a parameterized number of slices, so it compares words that are four bits per slice wide. The lowest slice takes its relation from three cascade pins, so the whole chain can itself sit under a further stage. When the chain is used on its own, tie the match pin high and the other two low. The logic is purely combinational, with no clock, storage or handshake. BCD digits need no special handling, because the codes 0 to 9 order the same way as plain binary.

Top module: `mag_cmp_chain`

## Requirements
- R1: When exactly one cascade pin is high, exactly one of `gt_o`, `lt_o`, `eq_o` is high.
- R2: Within a slice, the highest bit position where A and B differ decides the result: `gt_o` is high if A has the 1 there, otherwise `lt_o` is high. Lower bits do not affect the result.
- R3: When A equals B, `{gt_o, lt_o, eq_o}` copies `{cas_gt_i, cas_lt_i, cas_eq_i}` pin for pin, with each output following its own cascade pin.
- R4: The copy of R3 also holds for patterns that are not one-hot. All three cascade pins high give all three outputs high, all low give all low, and mixed patterns such as greater plus equal come out unchanged.
- R5: With cascade pins {gt,lt,eq} = 3'b001, the outputs give the unsigned relation of the full 4·SLICES-bit words. A more significant slice that differs overrides every slice below it.
- R6: Words made of BCD digits (each nibble 0 to 9) compare in the same order as their decimal values.
- R7: The outputs depend only on the present inputs. The same inputs give the same outputs whatever was applied before.
- R8: When A differs from B, the cascade pins have no effect, including the all-high and all-low patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4*SLICES | Word A, unsigned; bits [3:0] belong to the lowest slice |
| b_i | input | 4*SLICES | Word B, unsigned, same layout as A |
| cas_gt_i | input | 1 | "A above" relation coming from below the lowest slice |
| cas_lt_i | input | 1 | "A below" relation coming from below the lowest slice |
| cas_eq_i | input | 1 | "A matches" relation coming from below the lowest slice |
| gt_o | output | 1 | A is greater than B |
| lt_o | output | 1 | A is less than B |
| eq_o | output | 1 | A matches B (or the copied cascade value) |

## Verification
The block has no clock, so the assertions are immediate checks. They are evaluated whenever an input changes, and they assume each input change settles before the next one arrives. The one-hot check assumes the cascade pins carry a one-hot code. All other checks accept any cascade pattern, because the pins are copied or ignored by rule. The bench changes inputs only on a rising edge of its own pacing clock and reads the outputs on the falling edge, so every sample sees a settled value. It sends every cascade pattern, including the all-high and all-low ones, both to a single slice and to the three-slice chain.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  localparam int unsigned NIB_W = 4;

  // Three-way relation carried between slices.
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } rel_t;

endpackage

// File: rtl/mag_cmp_bitcell.sv
module mag_cmp_bitcell (
  input  logic a_i,
  input  logic b_i,
  output logic diff_o,
  output logic a_wins_o
);

  assign diff_o   = a_i ^ b_i;
  assign a_wins_o = a_i & ~b_i;

endmodule

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
  import mag_cmp_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  rel_t         cas_i,
  output rel_t         rel_o
);

  localparam rel_t REL_GT = '{gt: 1'b1, lt: 1'b0, eq: 1'b0};
  localparam rel_t REL_LT = '{gt: 1'b0, lt: 1'b1, eq: 1'b0};

  logic [W-1:0] diff;
  logic [W-1:0] a_wins;

  for (genvar g = 0; g < W; g++) begin : g_bit
    mag_cmp_bitcell u_cell (
      .a_i      (a_i[g]),
      .b_i      (b_i[g]),
      .diff_o   (diff[g]),
      .a_wins_o (a_wins[g])
    );
  end

  // Scan from LSB upward; a higher differing bit overwrites a lower one,
  // so the most significant difference wins. No difference: pass cascade.
  always_comb begin
    rel_o = cas_i;
    for (int i = 0; i < int'(W); i++) begin
      if (diff[i]) rel_o = a_wins[i] ? REL_GT : REL_LT;
    end
  end

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int unsigned SLICES = 3
) (
  input  logic [NIB_W*SLICES-1:0] a_i,
  input  logic [NIB_W*SLICES-1:0] b_i,
  input  logic                    cas_gt_i,
  input  logic                    cas_lt_i,
  input  logic                    cas_eq_i,
  output logic                    gt_o,
  output logic                    lt_o,
  output logic                    eq_o
);

  localparam int unsigned WORD_W = NIB_W * SLICES;

  rel_t link [SLICES+1];

  assign link[0] = '{gt: cas_gt_i, lt: cas_lt_i, eq: cas_eq_i};

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    mag_cmp_slice #(.W(NIB_W)) u_slice (
      .a_i   (a_i[s*NIB_W +: NIB_W]),
      .b_i   (b_i[s*NIB_W +: NIB_W]),
      .cas_i (link[s]),
      .rel_o (link[s+1])
    );
  end

  assign gt_o = link[SLICES].gt;
  assign lt_o = link[SLICES].lt;
  assign eq_o = link[SLICES].eq;

  if (WORD_W < NIB_W) begin : g_bad_param
    initial $error("SLICES must be at least 1");
  end

endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk
  import mag_cmp_pkg::*;
#(
  parameter int unsigned SLICES = 3
) (
  input logic [NIB_W*SLICES-1:0] a_i,
  input logic [NIB_W*SLICES-1:0] b_i,
  input logic                    cas_gt_i,
  input logic                    cas_lt_i,
  input logic                    cas_eq_i,
  input logic                    gt_o,
  input logic                    lt_o,
  input logic                    eq_o
);

  localparam int unsigned TOP = NIB_W * SLICES - 1;
  localparam int unsigned BOT = NIB_W * (SLICES - 1);

  always_comb begin
    if ($onehot({cas_gt_i, cas_lt_i, cas_eq_i}))
      assert_onehot_out_R1: assert ($onehot({gt_o, lt_o, eq_o}));
    if (a_i == b_i)
      assert_equal_copies_cascade_R3: assert ({gt_o, lt_o, eq_o} == {cas_gt_i, cas_lt_i, cas_eq_i});
    if (a_i != b_i)
      assert_wide_order_R5: assert (gt_o == (a_i > b_i) && lt_o == (a_i < b_i));
    if (a_i != b_i)
      assert_cascade_ignored_R8: assert (!eq_o && (gt_o ^ lt_o));
    if (a_i[TOP:BOT] != b_i[TOP:BOT])
      assert_top_slice_decides_R2: assert (gt_o == (a_i[TOP:BOT] > b_i[TOP:BOT]));
  end

endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.SLICES(SLICES)) u_chk (.*);

// File: tb/mag_cmp_chain_tb.sv
module mag_cmp_chain_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Three-slice chain
  logic [11:0] a3, b3;
  logic [2:0]  c3;
  logic        gt3, lt3, eq3;
  // Single slice
  logic [3:0]  a1, b1;
  logic [2:0]  c1;
  logic        gt1, lt1, eq1;

  mag_cmp_chain #(.SLICES(3)) u_dut (
    .a_i(a3), .b_i(b3), .cas_gt_i(c3[2]), .cas_lt_i(c3[1]), .cas_eq_i(c3[0]),
    .gt_o(gt3), .lt_o(lt3), .eq_o(eq3)
  );

  mag_cmp_chain #(.SLICES(1)) u_one (
    .a_i(a1), .b_i(b1), .cas_gt_i(c1[2]), .cas_lt_i(c1[1]), .cas_eq_i(c1[0]),
    .gt_o(gt1), .lt_o(lt1), .eq_o(eq1)
  );

  // Behavioural model: {gt,lt,eq}
  function automatic logic [2:0] model(longint unsigned a, longint unsigned b, logic [2:0] cas);
    if (a > b) return 3'b100;
    if (a < b) return 3'b010;
    return cas;
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run3(string req, logic [11:0] a, logic [11:0] b, logic [2:0] c);
    @(posedge clk);
    a3 = a; b3 = b; c3 = c;
    @(negedge clk);
    check(req, {gt3, lt3, eq3}, model(a, b, c));
  endtask

  initial begin
    a3 = '0; b3 = '0; c3 = 3'b001;
    a1 = '0; b1 = '0; c1 = 3'b001;
    @(negedge clk);
    // Reset-like start: zero words with equal tie-off
    check("R3 start", {gt3, lt3, eq3}, 3'b001);
    check("R3 start slice", {gt1, lt1, eq1}, 3'b001);

    // Exhaustive single slice: R1 R2 R3 R4 R8
    for (int i = 0; i < 2048; i++) begin
      logic [3:0] ea, eb;
      logic [2:0] ec;
      string req;
      ea = i[3:0]; eb = i[7:4]; ec = i[10:8];
      @(posedge clk);
      a1 = ea; b1 = eb; c1 = ec;
      @(negedge clk);
      if (ea != eb) req = ($onehot(ec)) ? "R2 slice" : "R8 slice";
      else req = ($onehot(ec)) ? "R3 slice" : "R4 slice";
      check(req, {gt1, lt1, eq1}, model(ea, eb, ec));
      if ($onehot(ec)) check("R1 slice", {2'b00, $onehot({gt1, lt1, eq1})}, 3'b001);
    end

    // Boundary cases on the chain
    run3("R5 equal max", 12'hFFF, 12'hFFF, 3'b001);
    run3("R5 lsb above", 12'h001, 12'h000, 3'b001);
    run3("R5 lsb below", 12'hA50, 12'hA51, 3'b001);
    run3("R5 top overrides", 12'h100, 12'h0FF, 3'b001);
    run3("R5 top below", 12'h7FF, 12'h800, 3'b001);
    run3("R4 all high", 12'h5A5, 12'h5A5, 3'b111);
    run3("R4 all low", 12'h5A5, 12'h5A5, 3'b000);
    run3("R4 gt plus eq", 12'h3C3, 12'h3C3, 3'b101);
    run3("R8 all high ignored", 12'h002, 12'h001, 3'b111);
    run3("R8 all low ignored", 12'h001, 12'h002, 3'b000);

    // R7: same inputs after different history
    run3("R7 first", 12'h444, 12'h443, 3'b001);
    run3("R7 other", 12'h000, 12'hFFF, 3'b010);
    run3("R7 again", 12'h444, 12'h443, 3'b001);

    // Randomized chain, including forced equal and lowest-bit differences
    for (int k = 0; k < 1500; k++) begin
      logic [11:0] ra, rb;
      logic [2:0] rc;
      ra = 12'($urandom);
      rb = 12'($urandom);
      rc = 3'($urandom);
      if (k % 4 == 1) rb = ra;
      if (k % 4 == 2) rb = ra ^ 12'h001;
      run3((ra == rb) ? "R3 random equal" : "R5 random", ra, rb, rc);
    end

    // R6: BCD words
    for (int k = 0; k < 400; k++) begin
      int da, db;
      logic [11:0] pa, pb;
      da = int'($urandom % 1000);
      db = (k % 5 == 0) ? da : int'($urandom % 1000);
      pa = {4'(da / 100), 4'((da / 10) % 10), 4'(da % 10)};
      pb = {4'(db / 100), 4'((db / 10) % 10), 4'(db % 10)};
      @(posedge clk);
      a3 = pa; b3 = pb; c3 = 3'b001;
      @(negedge clk);
      check("R6 bcd", {gt3, lt3, eq3},
            (da > db) ? 3'b100 : (da < db) ? 3'b010 : 3'b001);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule